// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog for a system clock domain. A 15-bit down-counter moves by one on each tick strobe, and each tick stands for a 10 ms period. The tick strobe comes from logic that divides a slow reference clock. Each control action takes effect only when its own 16-bit key value is written to the correct offset. Software keeps the system alive by writing the reload key before the count runs out. If the count runs out, the block asks for a system reset and records a timeout code. It then reloads from the last programmed timeout and keeps counting.

To stop the timer, software must write two keys, to two offsets, in order. A key value written at the wrong point leaves the timer running. An event flag is set one tick before expiry. Software can mask this event, clear it, or force it, and it drives the interrupt output. A debug-mode input suspends counting unless an override bit is set.

The register bus carries 16-bit data at byte offsets that are multiples of four. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is a combinational function of `bus_addr`. Every access completes in its own cycle, so the bus has no back-pressure and no ready signal. Offsets that are not mapped read as zero, and writes to them are dropped.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, offset 0x0C reads 0xDABE (stopped), 0x10 reads 0x0000, 0x04 reads 6000, 0x24 reads 0, and `rst_req` and `irq` are low.
- R2: Writing 0xFEED to offset 0x00 loads the count from the timeout register. Any other value written there changes nothing. A reload in the same cycle as a tick wins over the tick.
- R3: Offset 0x04 holds a 15-bit timeout in ticks. Bit 15 of a write is dropped and reads back as 0.
- R4: Writing 0x2BAD to offset 0x08 and then 0xCAFE to offset 0x0C stops the timer. Offset 0x0C reads 0xDABE while stopped and 0x0000 while running.
- R5: Any write to 0x0C that is not 0xCAFE cancels a pending 0x2BAD. A write to 0x08 that is not 0x2BAD also cancels it. 0xCAFE written without a pending 0x2BAD is ignored.
- R6: Writing 0xACED to offset 0x1C starts a stopped timer, and 0x0C then reads 0x0000.
- R7: While running and not suspended, each cycle with `tick_en` high lowers the count by one. Offset 0x14 returns the count in bits 14:0. Bit 15 reads 1 exactly when the count will change at the next edge because of a tick.
- R8: A tick that finds the count at 1 or 0 is an expiry. On expiry `rst_req` is high for the cycle after that edge, the count reloads from the timeout register, and the timer stays running.
- R9: Offset 0x10 reads 0xCFE8 once an expiry has occurred. Writing 0xE8B4 returns it to 0x0000. An expiry in the same cycle as that write wins.
- R10: A tick that takes the count from 2 to 1 sets the event flag at offset 0x20 bit 0. Writing 1 to that bit clears the flag. A set in the same cycle as a clear wins.
- R11: `irq` equals the event flag ANDed with the mask at offset 0x24 bit 0. While bit 0 of offset 0x28 is 1, the event flag is set every cycle.
- R12: Offset 0x18 bit 0 is the debug override and bit 1 reads `dbg_mode`. With `dbg_mode` high and the override clear, ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | One-cycle strobe per 10 ms tick |
| dbg_mode | input | 1 | Debug mode is active |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Pre-expiry interrupt |

## Verification
The bench targets the following corner cases:
- A broken stop sequence, where a wrong value reaches 0x0C between the two keys. A design that kept the unlock pending would stop on a later lone 0xCAFE.
- A reload key written in the same cycle as a tick. A design that let the tick win would show a count one below the timeout.
- A tick with the count at 0 or 1. A design that stopped after expiry, or reloaded with the reset value, would differ at the next count read.
- A status clear and an event clear written in the same cycle as the expiry or event that sets them. A design that gave the write priority would lose the timeout code or the interrupt.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TMO    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_HALT   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DBG    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RESUME = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_EVT    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_FORCE  = 8'h28;

  localparam logic [DATA_W-1:0] KEY_RELOAD = 16'hFEED;
  localparam logic [DATA_W-1:0] KEY_ARM    = 16'h2BAD;
  localparam logic [DATA_W-1:0] KEY_HALT   = 16'hCAFE;
  localparam logic [DATA_W-1:0] KEY_RESUME = 16'hACED;
  localparam logic [DATA_W-1:0] KEY_STCLR  = 16'hE8B4;

  localparam logic [DATA_W-1:0] CODE_STOPPED = 16'hDABE;
  localparam logic [DATA_W-1:0] CODE_RUNNING = 16'h0000;
  localparam logic [DATA_W-1:0] CODE_EXPIRED = 16'hCFE8;
  localparam logic [DATA_W-1:0] CODE_NORMAL  = 16'h0000;
endpackage

// File: rtl/wdog_keyguard.sv
module wdog_keyguard (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_ok,
  input  logic halt_wr,
  input  logic halt_ok,
  input  logic resume_ok,
  output logic run_o
);
  logic armed_q;
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (halt_wr) begin
      armed_q <= 1'b0;
    end else if (arm_wr) begin
      armed_q <= arm_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (resume_ok) begin
      run_q <= 1'b1;
    end else if (halt_wr && halt_ok && armed_q) begin
      run_q <= 1'b0;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W       = 15,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feed,
  input  logic             step,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] tmo_o,
  output logic             expire_o,
  output logic             pre_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(DEF_TIMEOUT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tmo_q;
  logic             rst_q;
  logic             dec_ok;

  assign dec_ok   = step && !feed;
  assign expire_o = dec_ok && (cnt_q <= ONE);
  assign pre_o    = dec_ok && (cnt_q == TWO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q <= DEF_VAL;
    end else if (tmo_wr) begin
      tmo_q <= tmo_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= DEF_VAL;
    end else if (feed || expire_o) begin
      cnt_q <= tmo_q;
    end else if (dec_ok) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= expire_o;
  end

  assign count_o   = cnt_q;
  assign tmo_o     = tmo_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdog_event.sv
module wdog_event (
  input  logic clk,
  input  logic rst_n,
  input  logic pre,
  input  logic evt_clr,
  input  logic mask_wr,
  input  logic force_wr,
  input  logic wbit,
  output logic evt_o,
  output logic mask_o,
  output logic force_o,
  output logic irq_o
);
  logic evt_q;
  logic mask_q;
  logic force_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else if (pre || force_q) begin
      evt_q <= 1'b1;
    end else if (evt_clr) begin
      evt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (mask_wr)  mask_q  <= wbit;
      if (force_wr) force_q <= wbit;
    end
  end

  assign evt_o   = evt_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;
  assign irq_o   = evt_q & mask_q;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic              dbg_mode,
  output logic              rst_req,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic             wr;
  logic             run;
  logic             active;
  logic             step;
  logic             feed;
  logic             expire;
  logic             pre;
  logic             expired_q;
  logic             ovr_q;
  logic             evt;
  logic             mask_q;
  logic             force_q;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] tmo;

  assign wr     = bus_valid && bus_write;
  assign feed   = wr && (bus_addr == OFS_RELOAD) && (bus_wdata == KEY_RELOAD);
  assign active = run && (!dbg_mode || ovr_q);
  assign step   = active && tick_en;

  wdog_keyguard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_wr    (wr && (bus_addr == OFS_ARM)),
    .arm_ok    (bus_wdata == KEY_ARM),
    .halt_wr   (wr && (bus_addr == OFS_HALT)),
    .halt_ok   (bus_wdata == KEY_HALT),
    .resume_ok (wr && (bus_addr == OFS_RESUME) && (bus_wdata == KEY_RESUME)),
    .run_o     (run)
  );

  wdog_counter #(
    .CNT_W       (CNT_W),
    .DEF_TIMEOUT (DEF_TIMEOUT)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .feed      (feed),
    .step      (step),
    .tmo_wr    (wr && (bus_addr == OFS_TMO)),
    .tmo_wdata (bus_wdata[CNT_W-1:0]),
    .count_o   (count),
    .tmo_o     (tmo),
    .expire_o  (expire),
    .pre_o     (pre),
    .rst_req_o (rst_req)
  );

  wdog_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre      (pre),
    .evt_clr  (wr && (bus_addr == OFS_EVT) && bus_wdata[0]),
    .mask_wr  (wr && (bus_addr == OFS_MASK)),
    .force_wr (wr && (bus_addr == OFS_FORCE)),
    .wbit     (bus_wdata[0]),
    .evt_o    (evt),
    .mask_o   (mask_q),
    .force_o  (force_q),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expired_q <= 1'b0;
    end else if (expire) begin
      expired_q <= 1'b1;
    end else if (wr && (bus_addr == OFS_STAT) && (bus_wdata == KEY_STCLR)) begin
      expired_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (wr && (bus_addr == OFS_DBG)) begin
      ovr_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_TMO:   bus_rdata = {{PAD_W{1'b0}}, tmo};
      OFS_HALT:  bus_rdata = run ? CODE_RUNNING : CODE_STOPPED;
      OFS_STAT:  bus_rdata = expired_q ? CODE_EXPIRED : CODE_NORMAL;
      OFS_CNT:   bus_rdata = {step, {(PAD_W-1){1'b0}}, count};
      OFS_DBG:   bus_rdata = {{(DATA_W-2){1'b0}}, dbg_mode, ovr_q};
      OFS_EVT:   bus_rdata = {{(DATA_W-1){1'b0}}, evt};
      OFS_MASK:  bus_rdata = {{(DATA_W-1){1'b0}}, mask_q};
      OFS_FORCE: bus_rdata = {{(DATA_W-1){1'b0}}, force_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tick_en,
  input logic              rst_req,
  input logic              irq,
  input logic              run,
  input logic [CNT_W-1:0]  count,
  input logic              mask_q,
  input logic              expired_q
);
  logic feed_w;
  assign feed_w = bus_valid && bus_write && (bus_addr == OFS_RELOAD) && (bus_wdata == KEY_RELOAD);

  assert_rst_sets_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> expired_q);

  assert_rst_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick_en));

  assert_halt_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(bus_valid && bus_write && bus_addr == OFS_HALT && bus_wdata == KEY_HALT));

  assert_resume_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(bus_valid && bus_write && bus_addr == OFS_RESUME && bus_wdata == KEY_RESUME));

  assert_count_moves_on_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> $past(tick_en || feed_w));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q);
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tick_en   (tick_en),
  .rst_req   (rst_req),
  .irq       (irq),
  .run       (run),
  .count     (count),
  .mask_q    (mask_q),
  .expired_q (expired_q)
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        rst_req;
  logic        irq;

  int total = 0;
  int fails = 0;

  // reference state built from the requirements
  int  m_count = 6000;
  int  m_tmo = 6000;
  bit  m_run = 0, m_armed = 0, m_stat = 0, m_evt = 0, m_mask = 0, m_force = 0;
  bit  m_ovr = 0, m_rst = 0, m_dbg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .dbg_mode(dbg_mode), .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd_model(logic [7:0] a);
    case (a)
      8'h04: return 16'(m_tmo);
      8'h0C: return m_run ? 16'h0000 : 16'hDABE;
      8'h10: return m_stat ? 16'hCFE8 : 16'h0000;
      8'h14: return 16'(m_count);
      8'h18: return {14'b0, m_dbg, m_ovr};
      8'h20: return {15'b0, m_evt};
      8'h24: return {15'b0, m_mask};
      8'h28: return {15'b0, m_force};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_update(bit wr, logic [7:0] a, logic [15:0] d, bit tk, bit dg);
    bit act, ex, pre;
    int nc;
    act = m_run && (!dg || m_ovr);
    ex = 0; pre = 0; nc = m_count;
    if (wr && a == 8'h00 && d == 16'hFEED) nc = m_tmo;
    else if (act && tk) begin
      if (m_count <= 1) begin ex = 1; nc = m_tmo; end
      else begin nc = m_count - 1; pre = (m_count == 2); end
    end
    m_evt = (pre || m_force) ? 1'b1 : ((wr && a == 8'h20 && d[0]) ? 1'b0 : m_evt);
    m_stat = ex ? 1'b1 : ((wr && a == 8'h10 && d == 16'hE8B4) ? 1'b0 : m_stat);
    if (wr && a == 8'h1C && d == 16'hACED) m_run = 1;
    else if (wr && a == 8'h0C && d == 16'hCAFE && m_armed) m_run = 0;
    if (wr && a == 8'h0C) m_armed = 0;
    else if (wr && a == 8'h08) m_armed = (d == 16'h2BAD);
    if (wr && a == 8'h04) m_tmo = int'(d[14:0]);
    if (wr && a == 8'h18) m_ovr = d[0];
    if (wr && a == 8'h24) m_mask = d[0];
    if (wr && a == 8'h28) m_force = d[0];
    m_count = nc;
    m_rst = ex;
    m_dbg = dg;
  endtask

  // one clock: drive at the low phase, update model at the edge, check after it
  task automatic step(bit wr, logic [7:0] a, logic [15:0] d, bit tk, bit dg,
                      logic [7:0] ra, string tag);
    bus_valid = wr; bus_write = wr; bus_addr = a; bus_wdata = d;
    tick_en = tk; dbg_mode = dg;
    if (!wr && a == 8'h14) begin
      #1;
      chk("R7 busy flag", {15'b0, bus_rdata[15]}, {15'b0, tk && m_run && (!dg || m_ovr)});
    end
    @(posedge clk);
    model_update(wr, a, d, tk, dg);
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tick_en = 0; bus_addr = ra;
    #1;
    chk("R8 rst_req", {15'b0, rst_req}, {15'b0, m_rst});
    chk("R11 irq", {15'b0, irq}, {15'b0, m_evt & m_mask});
    chk(tag, bus_rdata, rd_model(ra));
  endtask

  function automatic logic [15:0] key_for(logic [7:0] a);
    case (a)
      8'h00: return 16'hFEED;
      8'h04: return 16'($urandom % 6) | (($urandom % 2) == 0 ? 16'h8000 : 16'h0000);
      8'h08: return 16'h2BAD;
      8'h0C: return 16'hCAFE;
      8'h10: return 16'hE8B4;
      8'h1C: return 16'hACED;
      8'h28: return ($urandom % 8 == 0) ? 16'h0001 : 16'h0000;
      default: return 16'h0001;
    endcase
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_addr = 8'h0C; #1; chk("R1 stopped code", bus_rdata, 16'hDABE);
    bus_addr = 8'h10; #1; chk("R1 status", bus_rdata, 16'h0000);
    bus_addr = 8'h04; #1; chk("R1 timeout", bus_rdata, 16'd6000);
    bus_addr = 8'h24; #1; chk("R1 mask", bus_rdata, 16'h0000);
    chk("R1 outputs", {14'b0, rst_req, irq}, 16'h0000);
    @(negedge clk);

    step(1, 8'h04, 16'h8005, 0, 0, 8'h04, "R3 timeout bit15 dropped");
    step(1, 8'h00, 16'hFEED, 0, 0, 8'h14, "R2 reload");
    step(1, 8'h04, 16'h0007, 0, 0, 8'h04, "R3 timeout");
    step(1, 8'h00, 16'h1234, 0, 0, 8'h14, "R2 wrong key");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h14, "R7 stopped ignores tick");
    step(1, 8'h1C, 16'hACED, 0, 0, 8'h0C, "R6 resume");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h14, "R7 decrement");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h14, "R7 decrement");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h14, "R7 decrement");
    step(1, 8'h24, 16'h0001, 0, 0, 8'h24, "R11 mask set");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h20, "R10 event at one");
    step(1, 8'h20, 16'h0001, 0, 0, 8'h20, "R10 clear");
    step(0, 8'h14, 16'h0000, 1, 0, 8'h10, "R9 expired code");
    step(0, 8'h00, 16'h0000, 0, 0, 8'h14, "R8 reload after expiry");
    step(0, 8'h00, 16'h0000, 0, 0, 8'h0C, "R8 still running");
    step(1, 8'h10, 16'h1111, 0, 0, 8'h10, "R9 wrong clear key");
    step(1, 8'h10, 16'hE8B4, 0, 0, 8'h10, "R9 cleared");
    // feed wins over tick
    step(1, 8'h00, 16'hFEED, 1, 0, 8'h14, "R2 feed over tick");
    // count to 0 then tick on zero count with timeout 0
    step(1, 8'h04, 16'h0000, 0, 0, 8'h04, "R3 zero timeout");
    step(1, 8'h00, 16'hFEED, 0, 0, 8'h14, "R2 reload zero");
    step(1, 8'h10, 16'hE8B4, 1, 0, 8'h10, "R9 expiry wins over clear");
    step(1, 8'h04, 16'h0003, 0, 0, 8'h14, "R8 zero reload");
    // R5 broken sequences
    step(1, 8'h0C, 16'hCAFE, 0, 0, 8'h0C, "R5 lone halt key");
    step(1, 8'h08, 16'h2BAD, 0, 0, 8'h0C, "R5 armed");
    step(1, 8'h0C, 16'h1111, 0, 0, 8'h0C, "R5 wrong second key");
    step(1, 8'h0C, 16'hCAFE, 0, 0, 8'h0C, "R5 unlock cancelled");
    step(1, 8'h08, 16'h2BAD, 0, 0, 8'h0C, "R4 armed");
    step(1, 8'h0C, 16'hCAFE, 0, 0, 8'h0C, "R4 stopped");
    // R12 debug suspend
    step(1, 8'h1C, 16'hACED, 0, 1, 8'h18, "R12 debug readback");
    step(1, 8'h00, 16'hFEED, 0, 1, 8'h14, "R2 reload");
    step(0, 8'h14, 16'h0000, 1, 1, 8'h14, "R12 suspended");
    step(1, 8'h18, 16'h0001, 0, 1, 8'h18, "R12 override set");
    step(0, 8'h14, 16'h0000, 1, 1, 8'h14, "R12 override counts");
    // R11 force
    step(1, 8'h28, 16'h0001, 0, 0, 8'h28, "R11 force set");
    step(1, 8'h20, 16'h0001, 0, 0, 8'h20, "R11 force holds event");
    step(1, 8'h28, 16'h0000, 0, 0, 8'h20, "R11 force cleared");
    step(1, 8'h20, 16'h0001, 0, 0, 8'h20, "R10 clear after force");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      bit wr;
      logic [7:0] a, ra;
      logic [15:0] d;
      wr = ($urandom % 3) == 0;
      a  = 8'(($urandom % 11) * 4);
      ra = 8'(($urandom % 11) * 4);
      d  = ($urandom % 4 != 0) ? key_for(a) : 16'($urandom);
      if (a == 8'h04) d = key_for(a);
      step(wr, a, d, ($urandom % 2) == 1, ($urandom % 16) == 0, ra, "R7 random readback");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: run did not end, got hang expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule